// File: doc/BRIEF.md
# LVDS Pixel Serializer with Selectable Bit Mapping

This block takes one parallel pixel each pixel period and sends it out serially on four single-ended data lanes and one clock lane. A pixel is 8 bits each of red, green and blue plus four control bits: horizontal sync, vertical sync, data enable and one spare user bit. Each pixel period has seven bit slots. A clock enable at seven times the pixel rate (`bit_en`) moves the block from one slot to the next. So the block runs from a fast fabric clock, and the enable pattern alone sets the line rate.

A static selector picks one of three bit-to-slot layouts:
- an 18-bit layout on three lanes, carrying only the upper six bits of each colour;
- a 24-bit layout that puts the upper colour bits on lanes 0 to 2 and the two low bits of each colour on lane 3;
- a 24-bit layout that puts the lower six colour bits on lanes 0 to 2 and the two top bits of each colour on lane 3.

A mirror input reverses the order in which each data lane sends its seven slots. The block captures the pixel, the layout and the mirror setting together at the start of each pixel period. It gives a one-cycle strobe at that moment so the upstream source can present the next pixel.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: The slot index steps 0,1,…,6,0 on each clock where `bit_en` is high. Outputs change only on the clock after an enabled edge. `clk_lane` shows the pattern 1,1,0,0,0,1,1 for slots 0 to 6, so slot 0 starts each pixel.
- R2: A synchronous active-high `rst` sets the slot index to 0, drives every data lane low, sets `clk_lane` to 1 and `pix_take` to 0. It also clears the stored pixel, so the lanes stay low until the first capture, which happens on the seventh enable after reset.
- R3: With `map_sel` 0 (and also the unused code 3), the 18-bit layout is used. Lane 0 sends G2, R7, R6, R5, R4, R3, R2 for slots 0 to 6. Lane 1 sends B3, B2, G7, G6, G5, G4, G3. Lane 2 sends CTL2, CTL1, CTL0, B7, B6, B5, B4. Lane 3 stays low, and colour bits 1 and 0 have no effect on any lane.
- R4: With `map_sel` 1, lanes 0 to 2 follow the R3 layout. Lane 3 sends CTL3, B1, B0, G1, G0, R1, R0 for slots 0 to 6.
- R5: With `map_sel` 2, lanes 0 to 2 use the R3 layout moved down by two bit positions. Lane 0 sends G0, R5 to R0. Lane 1 sends B1, B0, G5 to G1. Lane 2 sends CTL2, CTL1, CTL0, B5 to B2. Lane 3 sends CTL3, B7, B6, G7, G6, R7, R6.
- R6: When `mirror` is captured high, every data lane sends slot 6 first and slot 0 last. `clk_lane` keeps its R1 pattern.
- R7: The pixel, `map_sel` and `mirror` are sampled only on the enabled edge that moves the slot index from 6 to 0. Changes at any other time have no effect on the pixel being sent.
- R8: The control bits map as CTL0 = `hsync`, CTL1 = `vsync`, CTL2 = `de`, CTL3 = `user_ctl`.
- R9: `pix_take` is high for exactly one clock, the clock on which the slot-0 bits of a newly captured pixel are on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Slot-rate enable, seven per pixel |
| map_sel | input | 2 | Layout: 0 18-bit, 1 24-bit low bits on lane 3, 2 24-bit high bits on lane 3, 3 as 0 |
| mirror | input | 1 | Send slots 6 down to 0 |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync (CTL0) |
| vsync | input | 1 | Vertical sync (CTL1) |
| de | input | 1 | Data enable (CTL2) |
| user_ctl | input | 1 | Spare control bit (CTL3) |
| lane_data | output | 4 | Serial data lanes, bit n is lane n |
| clk_lane | output | 1 | Serial clock lane pattern |
| pix_take | output | 1 | Capture strobe for the pixel source |

## Verification
Every output is registered, so each slot's bits and `clk_lane` appear one clock after the enabled edge that selects them. The bench raises `bit_en` on a falling edge and reads all outputs on the next falling edge. It reads them again one idle clock later to confirm that nothing moved while `bit_en` was low. A pixel goes in on the falling edge before the enable that moves from slot 6 to slot 0. Its seven slots are then collected over that enable and the six after it. The inputs are scrambled right after the capturing enable, so any late sampling shows up as a mismatch. A behavioural deserializer rebuilds each pixel from the collected slots for every layout and mirror setting and compares it bit for bit.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int NUM_LANES = 4;
  localparam int NUM_SLOTS = 7;
  localparam int COLOR_W   = 8;
  localparam int CTL_W     = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef enum logic [1:0] {
    MAP_NARROW18 = 2'd0,
    MAP_LOWEXT24 = 2'd1,
    MAP_HIEXT24  = 2'd2,
    MAP_SPARE    = 2'd3
  } map_e;

  typedef struct packed {
    logic [CTL_W-1:0]   ctl;
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
  } pixel_t;

  typedef logic [NUM_SLOTS-1:0] slot_word_t;
endpackage

// File: rtl/lvds_slot_timer.sv
module lvds_slot_timer
  import lvds_ser_pkg::*;
#(
  parameter logic [NUM_SLOTS-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  output logic [SLOT_W-1:0] next_slot_o,
  output logic              load_o,
  output logic              clk_lane_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic              clk_q;
  logic              at_last;

  always_comb begin
    at_last     = (slot_q == LAST_SLOT);
    load_o      = bit_en && at_last;
    next_slot_o = at_last ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      clk_q  <= CLK_PATTERN[0];
    end else if (bit_en) begin
      slot_q <= next_slot_o;
      clk_q  <= CLK_PATTERN[next_slot_o];
    end
  end

  assign clk_lane_o = clk_q;

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_q <= LAST_SLOT);                                   // R1
  AST_SLOT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(slot_q) && $stable(clk_q));        // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    load_o |=> (slot_q == '0));                             // R1
endmodule

// File: rtl/lvds_bit_mapper.sv
module lvds_bit_mapper
  import lvds_ser_pkg::*;
(
  input  pixel_t                      px,
  input  map_e                        mode,
  output slot_word_t [NUM_LANES-1:0]  words
);
  localparam int WIN_W = COLOR_W - 2;

  logic             hi_ext;
  logic             narrow;
  logic [WIN_W-1:0] rw, gw, bw;
  logic [1:0]       re, ge, be;

  always_comb begin
    hi_ext = (mode == MAP_HIEXT24);
    narrow = (mode == MAP_NARROW18) || (mode == MAP_SPARE);
    // six-bit window on lanes 0..2, two-bit remainder on lane 3
    rw = hi_ext ? px.r[WIN_W-1:0] : px.r[COLOR_W-1:2];
    gw = hi_ext ? px.g[WIN_W-1:0] : px.g[COLOR_W-1:2];
    bw = hi_ext ? px.b[WIN_W-1:0] : px.b[COLOR_W-1:2];
    re = hi_ext ? px.r[COLOR_W-1:WIN_W] : px.r[1:0];
    ge = hi_ext ? px.g[COLOR_W-1:WIN_W] : px.g[1:0];
    be = hi_ext ? px.b[COLOR_W-1:WIN_W] : px.b[1:0];

    // bit s of each word is slot s
    words[0] = {rw[0], rw[1], rw[2], rw[3], rw[4], rw[5], gw[0]};
    words[1] = {gw[1], gw[2], gw[3], gw[4], gw[5], bw[0], bw[1]};
    words[2] = {bw[2], bw[3], bw[4], bw[5], px.ctl[0], px.ctl[1], px.ctl[2]};
    words[3] = narrow ? '0 :
               {re[0], re[1], ge[0], ge[1], be[0], be[1], px.ctl[3]};
  end
endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter
  import lvds_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              load,
  input  slot_word_t        fresh_word,
  input  logic [SLOT_W-1:0] pick,
  output logic              lane_o
);
  slot_word_t held_q;
  logic       out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      out_q  <= 1'b0;
    end else if (bit_en) begin
      if (load) held_q <= fresh_word;
      out_q <= load ? fresh_word[pick] : held_q[pick];
    end
  end

  assign lane_o = out_q;

  AST_LANE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(out_q));                            // R1
  AST_WORD_KEPT: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(held_q));                             // R7
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
#(
  parameter logic [NUM_SLOTS-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic [1:0]           map_sel,
  input  logic                 mirror,
  input  logic [COLOR_W-1:0]   red,
  input  logic [COLOR_W-1:0]   green,
  input  logic [COLOR_W-1:0]   blue,
  input  logic                 hsync,
  input  logic                 vsync,
  input  logic                 de,
  input  logic                 user_ctl,
  output logic [NUM_LANES-1:0] lane_data,
  output logic                 clk_lane,
  output logic                 pix_take
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  pixel_t                     px_in;
  slot_word_t [NUM_LANES-1:0] fresh_words;
  logic [SLOT_W-1:0]          next_slot;
  logic [SLOT_W-1:0]          pick;
  logic                       load;
  logic                       mirror_q;
  logic                       mirror_eff;
  logic                       take_q;
  logic                       narrow_in;

  always_comb begin
    px_in.ctl  = {user_ctl, de, vsync, hsync};
    px_in.r    = red;
    px_in.g    = green;
    px_in.b    = blue;
    narrow_in  = (map_sel == MAP_NARROW18) || (map_sel == MAP_SPARE);
    mirror_eff = load ? mirror : mirror_q;
    pick       = mirror_eff ? (LAST_SLOT - next_slot) : next_slot;
  end

  lvds_slot_timer #(.CLK_PATTERN(CLK_PATTERN)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .next_slot_o (next_slot),
    .load_o      (load),
    .clk_lane_o  (clk_lane)
  );

  lvds_bit_mapper u_mapper (
    .px    (px_in),
    .mode  (map_e'(map_sel)),
    .words (fresh_words)
  );

  for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
    lvds_lane_shifter u_shift (
      .clk        (clk),
      .rst        (rst),
      .bit_en     (bit_en),
      .load       (load),
      .fresh_word (fresh_words[ln]),
      .pick       (pick),
      .lane_o     (lane_data[ln])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mirror_q <= 1'b0;
      take_q   <= 1'b0;
    end else begin
      if (load) mirror_q <= mirror;
      take_q <= load;
    end
  end

  assign pix_take = take_q;

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pix_take |=> !pix_take);                                // R9
  AST_TAKE_WITH_CLK: assert property (@(posedge clk) disable iff (rst)
    load |=> pix_take && clk_lane);                         // R9
  AST_NARROW_LANE3: assert property (@(posedge clk) disable iff (rst)
    load && narrow_in |=> !lane_data[3]);                   // R3
  AST_MIRROR_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(mirror_q));                           // R7
endmodule

// File: tb/lvds_pixel_serializer_bench.sv
module lvds_pixel_serializer_bench;
  import lvds_ser_pkg::*;

  localparam logic [6:0] PAT = 7'b1100011;
  // {mirror, map_sel[1:0], ctl[3:0], red, green, blue}
  localparam logic [30:0] VEC [12] = '{
    {1'b0, 2'd0, 4'h5, 24'hFFFFFF},
    {1'b0, 2'd0, 4'hA, 24'h0303_03},
    {1'b0, 2'd1, 4'hF, 24'h8142C3},
    {1'b0, 2'd1, 4'h8, 24'h010203},
    {1'b0, 2'd2, 4'h3, 24'hC0C0C0},
    {1'b0, 2'd2, 4'hC, 24'h3F5A96},
    {1'b1, 2'd0, 4'h6, 24'hA5F00F},
    {1'b1, 2'd1, 4'h9, 24'h80_0001},
    {1'b1, 2'd2, 4'h1, 24'h7E1881},
    {1'b1, 2'd3, 4'h7, 24'hFE7F01},
    {1'b0, 2'd3, 4'hE, 24'h55AA33},
    {1'b1, 2'd1, 4'h0, 24'h000000}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic [1:0] map_sel = '0;
  logic       mirror = 1'b0;
  logic [7:0] red = '0, green = '0, blue = '0;
  logic       hsync = 1'b0, vsync = 1'b0, de = 1'b0, user_ctl = 1'b0;
  logic [3:0] lane_data;
  logic       clk_lane;
  logic       pix_take;

  int checks = 0;
  int fails  = 0;
  int slot_m = 0;
  logic [31:0] lfsr = 32'h1D2C3B4A;

  always #5 clk = ~clk;

  lvds_pixel_serializer u_lvds_pixel_serializer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .map_sel(map_sel), .mirror(mirror),
    .red(red), .green(green), .blue(blue), .hsync(hsync), .vsync(vsync),
    .de(de), .user_ctl(user_ctl), .lane_data(lane_data),
    .clk_lane(clk_lane), .pix_take(pix_take)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // one enabled edge, sample, then one idle clock to confirm outputs hold
  task automatic step(output logic [3:0] got);
    logic [3:0] seen;
    logic       seen_clk;
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
    slot_m = (slot_m == 6) ? 0 : slot_m + 1;
    check(clk_lane == PAT[slot_m], "R1", "clock lane pattern", clk_lane, PAT[slot_m]);
    check(pix_take == (slot_m == 0), "R9", "capture strobe", pix_take, slot_m == 0);
    seen = lane_data;
    seen_clk = clk_lane;
    got = lane_data;
    @(negedge clk);
    check(lane_data == seen && clk_lane == seen_clk, "R1", "hold without enable",
          {lane_data, clk_lane}, {seen, seen_clk});
    check(pix_take == 1'b0, "R9", "strobe width", pix_take, 0);
  endtask

  function automatic logic [27:0] decode(input logic [6:0] w [4], input logic [1:0] m);
    logic [7:0] r = '0, g = '0, b = '0;
    logic [3:0] c = '0;
    int base = (m == 2'd2) ? 0 : 2;
    g[base] = w[0][0];
    for (int i = 0; i < 6; i++) r[base + 5 - i] = w[0][1 + i];
    b[base + 1] = w[1][0];
    b[base]     = w[1][1];
    for (int i = 0; i < 5; i++) g[base + 5 - i] = w[1][2 + i];
    c[2] = w[2][0]; c[1] = w[2][1]; c[0] = w[2][2];
    for (int i = 0; i < 4; i++) b[base + 5 - i] = w[2][3 + i];
    if (m == 2'd1) begin
      c[3] = w[3][0]; b[1] = w[3][1]; b[0] = w[3][2];
      g[1] = w[3][3]; g[0] = w[3][4]; r[1] = w[3][5]; r[0] = w[3][6];
    end else if (m == 2'd2) begin
      c[3] = w[3][0]; b[7] = w[3][1]; b[6] = w[3][2];
      g[7] = w[3][3]; g[6] = w[3][4]; r[7] = w[3][5]; r[6] = w[3][6];
    end
    return {c, r, g, b};
  endfunction

  // bench sits on slot 6; applies a pixel, scrambles inputs after capture
  task automatic send(input logic [30:0] v);
    logic [6:0] w [4];
    logic [3:0] got;
    logic [27:0] exp_px, got_px;
    logic        mir = v[30];
    logic [1:0]  m = v[29:28];
    bit          narrow = (m == 2'd0) || (m == 2'd3);
    string       req;
    mirror = mir; map_sel = m;
    {user_ctl, de, vsync, hsync} = v[27:24];
    red = v[23:16]; green = v[15:8]; blue = v[7:0];
    for (int l = 0; l < 4; l++) w[l] = '0;
    for (int k = 0; k < 7; k++) begin
      step(got);
      if (k == 0) begin   // R7: later changes must not reach this pixel
        mirror = ~mirror; map_sel = map_sel + 2'd1;
        {user_ctl, de, vsync, hsync} = ~v[27:24];
        red = ~red; green = green ^ 8'h5A; blue = ~blue;
      end
      for (int l = 0; l < 4; l++) w[l][mir ? 6 - k : k] = got[l];
    end
    exp_px = narrow ? {1'b0, v[26:24], v[23:16] & 8'hFC, v[15:8] & 8'hFC, v[7:0] & 8'hFC}
                    : v[27:0];
    got_px = decode(w, m);
    req = narrow ? "R3" : (m == 2'd1) ? "R4" : "R5";
    if (mir) req = {req, " R6"};
    req = {req, " R7"};
    check(got_px[23:0] == exp_px[23:0], req, "colour round trip", got_px[23:0], exp_px[23:0]);
    check(got_px[27:24] == exp_px[27:24], "R8", "control bits", got_px[27:24], exp_px[27:24]);
    if (narrow) check(w[3] == 7'd0, "R3", "lane 3 idle", w[3], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] got;
    // R2: reset with enable and busy inputs
    bit_en = 1'b1; red = 8'hFF; green = 8'hFF; blue = 8'hFF;
    hsync = 1'b1; vsync = 1'b1; de = 1'b1; user_ctl = 1'b1; map_sel = 2'd1;
    repeat (3) @(negedge clk);
    check(lane_data == 4'h0, "R2", "lanes in reset", lane_data, 0);
    check(clk_lane == 1'b1, "R2", "clock lane in reset", clk_lane, 1);
    check(pix_take == 1'b0, "R2", "strobe in reset", pix_take, 0);
    rst = 1'b0; bit_en = 1'b0; slot_m = 0;
    for (int k = 0; k < 6; k++) begin
      step(got);
      check(got == 4'h0, "R2", "lanes low before first capture", got, 0);
    end

    for (int i = 0; i < 12; i++) send(VEC[i]);

    for (int i = 0; i < 24; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      send({1'((i / 4) % 2), 2'(i % 4), lfsr[27:0]});
    end

    // R2: reset in the middle of a pixel restarts the slot count
    for (int k = 0; k < 3; k++) step(got);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check(lane_data == 4'h0, "R2", "lanes after mid-run reset", lane_data, 0);
    check(clk_lane == 1'b1, "R2", "clock lane after mid-run reset", clk_lane, 1);
    slot_m = 0;
    for (int k = 0; k < 6; k++) begin
      step(got);
      check(got == 4'h0, "R2", "stored pixel cleared", got, 0);
    end
    send({1'b0, 2'd2, 4'hB, 24'hDEAD5E});

    summary();
    $finish;
  end
endmodule